// File: doc/BRIEF.md
# Double-by-single restoring divider

This block divides an unsigned double-length dividend, given as a high word and a low word, by a single-length divisor. It returns a single-length quotient and a single-length remainder. A one-cycle `start` strobe launches an operation. The block works out one quotient bit per clock, most significant first. It shifts the partial remainder left, brings in the next low-word bit, and subtracts the divisor whenever the divisor fits.

The quotient must fit in one word. So the block checks the divisor against the dividend high word when it accepts the operation. If the divisor is not strictly greater than the high word, the block refuses the operation at once. This test also covers a zero divisor. On a refusal the block raises the overflow flag and pulses `done` in the very next cycle. The quotient and remainder outputs then show the dividend low and high words unchanged.

The controller has three states:
- `ST_IDLE`: waiting for `start`.
- `ST_RUN`: one shift-and-subtract step per cycle, for W cycles.
- `ST_FINISH`: `done` is high for one cycle.

The transitions are:
- `ST_IDLE` to `ST_RUN` on an accepted start.
- `ST_IDLE` to `ST_FINISH` on a refused start.
- `ST_RUN` to `ST_RUN` while the step counter is below W-1.
- `ST_RUN` to `ST_FINISH` on the last step.
- `ST_FINISH` to `ST_IDLE` always.
- `ST_IDLE` to `ST_IDLE` without `start`.

Top module: `dbl_divider`

## Requirements
- R1: After reset, `done`, `ovf`, `quo` and `rem` are all zero.
- R2: A start taken in idle with `dvs <= dvd_hi` (zero divisor included) gives `ovf`=1 together with `done`=1 in the cycle right after the sampling clock edge.
- R3: On a refused operation, `quo` equals the sampled `dvd_lo` and `rem` equals the sampled `dvd_hi`.
- R4: On an accepted operation (`dvs > dvd_hi`), `done` brings `ovf`=0, `quo` = floor({dvd_hi,dvd_lo}/dvs) and `rem` = {dvd_hi,dvd_lo} mod dvs.
- R5: For an accepted operation, `done` is high in the cycle that follows the (W+1)-th rising edge, counting the edge that samples `start` as the first. For W=16 that is 17 edges.
- R6: `done` is high for exactly one cycle per operation.
- R7: `start` is ignored while an operation is running or `done` is high. The result is that of the operation first accepted.
- R8: `quo`, `rem` and `ovf` keep their values after `done` until the next accepted start.
- R9: Boundary cases: dividend 0:65535 by 1 gives 65535 remainder 0. A high word of dvs-1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch strobe, sampled in idle only |
| dvd_hi | input | W | Dividend high word |
| dvd_lo | input | W | Dividend low word |
| dvs | input | W | Divisor |
| quo | output | W | Quotient, or dividend low word on refusal |
| rem | output | W | Remainder, or dividend high word on refusal |
| ovf | output | 1 | Operation refused (quotient would not fit) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the divider with its default width W=16. This gives the full one-word corner values: 65535 divided by 1, a high word one below the divisor, a divisor of all ones, and a zero divisor. It also gives the 17-cycle latency. A behavioural model checks every clock whether `done` must be high and which result must be shown. With that model, starts issued during a run, held starts, and results that must stay put between operations are all checked. A stream of pseudo-random operand triples adds both accepted and refused cases to the fixed corners.

// File: rtl/dbl_div_pkg.sv
package dbl_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } div_state_e;

endpackage

// File: rtl/dbl_div_step.sv
// One restoring step: shift the partial remainder left, bring in the next
// dividend bit, subtract the divisor when it fits.
module dbl_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] part_rem,
    input  logic         next_bit,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] part_rem_nxt,
    output logic         quo_bit
);

    logic [W:0] shifted;

    always_comb begin
        shifted = {part_rem, next_bit};
        quo_bit = (shifted >= {1'b0, divisor});
        // The true difference is below the divisor, so W bits are enough.
        if (quo_bit) begin
            part_rem_nxt = shifted[W-1:0] - divisor;
        end else begin
            part_rem_nxt = shifted[W-1:0];
        end
    end

endmodule

// File: rtl/dbl_div_ctrl.sv
module dbl_div_ctrl
    import dbl_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fits,
    output logic load,
    output logic step_en,
    output logic done,
    output logic idle
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (state_q == ST_RUN) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = fits ? ST_RUN : ST_FINISH;
                end
            end
            ST_RUN: begin
                if (cnt_q == LAST) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle    = (state_q == ST_IDLE);
        load    = idle && start;
        step_en = (state_q == ST_RUN);
        done    = (state_q == ST_FINISH);
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a start during a run neither restarts nor stalls the step count
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cnt_q != LAST) |=> (step_en && cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/dbl_div_datapath.sv
module dbl_div_datapath #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         reject,
    input  logic         step_en,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf
);

    logic [W-1:0] rem_q, quo_q, dvs_q;
    logic         ovf_q;
    logic [W-1:0] rem_nxt;
    logic         qbit;

    dbl_div_step #(.W(W)) u_step (
        .part_rem     (rem_q),
        .next_bit     (quo_q[W-1]),
        .divisor      (dvs_q),
        .part_rem_nxt (rem_nxt),
        .quo_bit      (qbit)
    );

    // quo_q doubles as the dividend shift register: low-word bits leave at
    // the top while quotient bits enter at the bottom.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            ovf_q <= 1'b0;
        end else if (load) begin
            rem_q <= dvd_hi;
            quo_q <= dvd_lo;
            dvs_q <= dvs;
            ovf_q <= reject;
        end else if (step_en) begin
            rem_q <= rem_nxt;
            quo_q <= {quo_q[W-2:0], qbit};
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;
    assign ovf = ovf_q;

    // R4: the partial remainder stays below the divisor throughout a run
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (rem_q < dvs_q));

endmodule

// File: rtl/dbl_divider.sv
module dbl_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf,
    output logic         done
);

    logic fits, load, step_en, idle;

    assign fits = (dvs > dvd_hi);

    dbl_div_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .fits    (fits),
        .load    (load),
        .step_en (step_en),
        .done    (done),
        .idle    (idle)
    );

    dbl_div_datapath #(.W(W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .reject  (!fits),
        .step_en (step_en),
        .dvd_hi  (dvd_hi),
        .dvd_lo  (dvd_lo),
        .dvs     (dvs),
        .quo     (quo),
        .rem     (rem),
        .ovf     (ovf)
    );

    assert_reject_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && dvs <= dvd_hi) |=> (done && ovf));

    assert_reject_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && dvs <= dvd_hi) |=> (quo == $past(dvd_lo) && rem == $past(dvd_hi)));

    assert_accept_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && dvs > dvd_hi) |=> (!ovf && !done));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> ($stable(quo) && $stable(rem) && $stable(ovf)));

endmodule

// File: tb/dbl_divider_bench.sv
`timescale 1ns/1ps
module dbl_divider_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
    logic [W-1:0] quo, rem;
    logic         ovf, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state
    int           left = 0;
    bit           have_res = 0;
    logic [W-1:0] e_quo = '0, e_rem = '0;
    logic         e_ovf = 1'b0;

    always #10 clk = ~clk;

    dbl_divider #(.W(W)) u_dbl_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
        .quo(quo), .rem(rem), .ovf(ovf), .done(done)
    );

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            left = 0;
            have_res = 0;
        end else if (left == 0) begin
            if (start) begin
                logic [2*W-1:0] dd;
                dd = {dvd_hi, dvd_lo};
                have_res = 1;
                if (dvs <= dvd_hi) begin
                    e_ovf = 1'b1; e_quo = dvd_lo; e_rem = dvd_hi; left = 1;
                end else begin
                    e_ovf = 1'b0;
                    e_quo = W'(dd / {{W{1'b0}}, dvs});
                    e_rem = W'(dd % {{W{1'b0}}, dvs});
                    left = W + 1;
                end
            end
        end else begin
            left = left - 1;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5/R6/R7 done timing", W'(done), W'(left == 1));
            if (!have_res && left == 0) begin
                chk("R1 quo", quo, '0);
                chk("R1 rem", rem, '0);
                chk("R1 ovf", W'(ovf), '0);
            end else if (have_res && left == 1) begin
                if (e_ovf) begin
                    chk("R2 ovf", W'(ovf), W'(1));
                    chk("R3 quo", quo, e_quo);
                    chk("R3 rem", rem, e_rem);
                end else begin
                    chk("R4 ovf", W'(ovf), '0);
                    chk("R4 quo", quo, e_quo);
                    chk("R4 rem", rem, e_rem);
                end
            end else if (have_res && left == 0) begin
                chk("R8 quo held", quo, e_quo);
                chk("R8 rem held", rem, e_rem);
                chk("R8 ovf held", W'(ovf), W'(e_ovf));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic launch(input logic [W-1:0] h, input logic [W-1:0] l,
                          input logic [W-1:0] d, input int hold);
        @(negedge clk);
        dvd_hi = h; dvd_lo = l; dvs = d; start = 1'b1;
        repeat (hold) @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [W-1:0] h, input logic [W-1:0] l, input logic [W-1:0] d);
        launch(h, l, d, 1);
        repeat (W + 4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);                 // R1 checked while idle
        run_op(16'h0000, 16'hFFFF, 16'h0001);      // R9 65535 / 1
        run_op(16'h0000, 16'h0064, 16'h0000);      // R2 zero divisor
        run_op(16'h0005, 16'hABCD, 16'h0005);      // R2 equal high word
        run_op(16'h0005, 16'h1111, 16'h0004);      // R3 smaller divisor
        run_op(16'h1234, 16'h5678, 16'h1235);      // R9 high word dvs-1
        run_op(16'hFFFE, 16'hFFFF, 16'hFFFF);      // R4 all-ones divisor
        run_op(16'h0000, 16'h0000, 16'h0007);      // R4 zero dividend
        // R7: start held for several cycles, then a second start mid-run
        launch(16'h0003, 16'h0F0F, 16'h0010, 3);
        repeat (4) @(negedge clk);
        launch(16'h0000, 16'h0001, 16'h0000, 1);
        repeat (W + 4) @(negedge clk);
        // R7: start exactly in the done cycle is ignored
        launch(16'h0001, 16'h0002, 16'h0003, 1);
        repeat (W - 1) @(negedge clk);
        launch(16'h0000, 16'h0009, 16'h0002, 1);
        repeat (W + 4) @(negedge clk);
        // pseudo-random stream
        begin
            logic [31:0] s;
            s = 32'h1ACE_B00C;
            for (int i = 0; i < 60; i++) begin
                logic [W-1:0] h, l, d;
                s = s * 32'd1664525 + 32'd1013904223;  h = s[31:16];
                s = s * 32'd1664525 + 32'd1013904223;  l = s[31:16];
                s = s * 32'd1664525 + 32'd1013904223;  d = s[31:16];
                if (i % 3 == 0) h = h >> 4;
                run_op(h, l, d);
            end
        end
        finish_run();
    end

endmodule